// File: doc/BRIEF.md
# Encoder Velocity Capture Timer

This block turns the decoded pulse stream of a quadrature position decoder into a speed sample. It accepts a one-cycle strobe for each decoded encoder step and a direction level. It also accepts a programmable window length, a threshold and a restart strobe. A free-running window timer splits time into measurement windows of `reload_val + 1` clock cycles. A pulse counter counts the steps that arrive inside each window.

When a window closes, the running count is moved into a capture register. A one-cycle window-done event is raised, and the timer starts the next window from zero. The captured count is compared against a threshold; when it falls short, a low-speed event is raised together with the window-done event. Software turns the captured count into a rotational speed. The decoder's edge multiplication (2x or 4x of the line count per revolution) is already present in the strobe rate, so the block counts strobes as they come.

Top module: `vel_capture_timer`

## Requirements
- R1: While `rst` is high at a clock edge, every output goes to zero on that edge.
- R2: A window lasts `reload_val + 1` cycles. `window_done` is high for exactly one cycle at each window end, and it is high for nothing else.
- R3: `timer_now` starts at 0 in each window and rises by one per cycle up to the window's reload value. It then returns to 0.
- R4: On window end, `captured_count` takes the number of strobes counted in the closing window. The running count restarts in the same cycle. A strobe present in the closing cycle counts as the first strobe of the new window.
- R5: `slow_event` pulses together with `window_done` when the captured count is strictly less than `vel_cmp_val`. It stays low when the two are equal or the count is greater.
- R6: When `vel_clear` is high, the timer and the running count go to 0 on the next edge. No capture takes place, a strobe in that same cycle is discarded, and a fresh reload value is taken.
- R7: `pulse_event` is high for one cycle after each accepted strobe, that is a strobe not discarded by `vel_clear`.
- R8: The running count stops at all ones and does not wrap within a window.
- R9: A change of `reload_val` during a window does not alter that window. It sets the length of the following window.
- R10: `captured_dir` takes, at window end, the `enc_dir` level seen with the last strobe counted before the closing cycle. It keeps its previous value when no strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_pulse | input | 1 | One-cycle strobe per decoded encoder step |
| enc_dir | input | 1 | Direction level from the decoder |
| vel_clear | input | 1 | Restart strobe for timer and running count |
| reload_val | input | TMR_W | Window length minus one |
| vel_cmp_val | input | CNT_W | Low-speed threshold |
| timer_now | output | TMR_W | Live window timer |
| pulse_count_now | output | CNT_W | Running strobe count of the open window |
| captured_count | output | CNT_W | Count captured at the last window end |
| captured_dir | output | 1 | Direction captured at the last window end |
| window_done | output | 1 | One-cycle window-end (timer overflow) event |
| slow_event | output | 1 | One-cycle below-threshold event |
| pulse_event | output | 1 | One-cycle event per accepted strobe |

## Verification
The hardest states to reach from the ports are the saturated counter and a strobe that lands exactly in the closing cycle of a window. The stimulus reaches saturation with a long window and a strobe held high on every cycle, so the count hits all ones well before the window closes. It reaches the boundary case by driving strobes on every cycle with short windows, so that each window end carries a strobe that must move into the new window. A cycle model feeds a queue of expected captures. The stimulus also changes the reload value and the threshold directly after a window end, and it raises a restart together with a strobe.

// File: rtl/vel_pkg.sv
package vel_pkg;
  // event pair produced at a window boundary
  typedef struct packed {
    logic done;
    logic slow;
  } vel_evt_t;

  // strict below-threshold test used at capture time
  function automatic logic below_thr(input logic [31:0] cnt, input logic [31:0] thr);
    return cnt < thr;
  endfunction
endpackage

// File: rtl/vel_window_timer.sv
module vel_window_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [TMR_W-1:0] reload_in,
  output logic [TMR_W-1:0] tmr_q,
  output logic             wrap
);
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  // reload value in force for the current window
  logic [TMR_W-1:0] rel_q;

  assign wrap = (tmr_q == rel_q) && !restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q <= '0;
      rel_q <= reload_in;
    end else if (restart || wrap) begin
      tmr_q <= '0;
      rel_q <= reload_in;
    end else begin
      tmr_q <= tmr_q + ONE;
    end
  end
endmodule

// File: rtl/vel_pulse_counter.sv
module vel_pulse_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             wrap,
  input  logic             pulse,
  input  logic             dir,
  output logic [CNT_W-1:0] cnt_q,
  output logic             dir_q,
  output logic             pevt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic take;
  assign take = pulse && !clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      pevt_q <= 1'b0;
    end else begin
      pevt_q <= take;
      if (take) dir_q <= dir;
      if (clear)
        cnt_q <= '0;
      else if (wrap)
        cnt_q <= pulse ? CNT_ONE : '0;   // boundary strobe opens the new window
      else if (pulse && (cnt_q != CNT_MAX))
        cnt_q <= cnt_q + CNT_ONE;
    end
  end
endmodule

// File: rtl/vel_capture_compare.sv
module vel_capture_compare
  import vel_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             dir_in,
  input  logic [CNT_W-1:0] cmp_in,
  output logic [CNT_W-1:0] cap_q,
  output logic             cap_dir_q,
  output logic             done_q,
  output logic             slow_q
);
  vel_evt_t evt_d;

  always_comb begin
    evt_d.done = wrap;
    evt_d.slow = wrap && below_thr(32'(cnt_in), 32'(cmp_in));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q     <= '0;
      cap_dir_q <= 1'b0;
      done_q    <= 1'b0;
      slow_q    <= 1'b0;
    end else begin
      done_q <= evt_d.done;
      slow_q <= evt_d.slow;
      if (wrap) begin
        cap_q     <= cnt_in;
        cap_dir_q <= dir_in;
      end
    end
  end
endmodule

// File: rtl/vel_capture_timer.sv
module vel_capture_timer #(
  parameter int TMR_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enc_pulse,
  input  logic             enc_dir,
  input  logic             vel_clear,
  input  logic [TMR_W-1:0] reload_val,
  input  logic [CNT_W-1:0] vel_cmp_val,
  output logic [TMR_W-1:0] timer_now,
  output logic [CNT_W-1:0] pulse_count_now,
  output logic [CNT_W-1:0] captured_count,
  output logic             captured_dir,
  output logic             window_done,
  output logic             slow_event,
  output logic             pulse_event
);
  logic             wrap;
  logic             last_dir;

  vel_window_timer #(.TMR_W(TMR_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart   (vel_clear),
    .reload_in (reload_val),
    .tmr_q     (timer_now),
    .wrap      (wrap)
  );

  vel_pulse_counter #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst    (rst),
    .clear  (vel_clear),
    .wrap   (wrap),
    .pulse  (enc_pulse),
    .dir    (enc_dir),
    .cnt_q  (pulse_count_now),
    .dir_q  (last_dir),
    .pevt_q (pulse_event)
  );

  vel_capture_compare #(.CNT_W(CNT_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .wrap      (wrap),
    .cnt_in    (pulse_count_now),
    .dir_in    (last_dir),
    .cmp_in    (vel_cmp_val),
    .cap_q     (captured_count),
    .cap_dir_q (captured_dir),
    .done_q    (window_done),
    .slow_q    (slow_event)
  );
endmodule

// File: rtl/vel_capture_timer_chk.sv
module vel_capture_timer_chk #(
  parameter int TMR_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             enc_pulse,
  input logic             enc_dir,
  input logic             vel_clear,
  input logic [TMR_W-1:0] reload_val,
  input logic [CNT_W-1:0] vel_cmp_val,
  input logic [TMR_W-1:0] timer_now,
  input logic [CNT_W-1:0] pulse_count_now,
  input logic [CNT_W-1:0] captured_count,
  input logic             captured_dir,
  input logic             window_done,
  input logic             slow_event,
  input logic             pulse_event
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R2: a window end always leaves the timer at zero
  p_done_zero_r2: assert property (@(posedge clk) disable iff (rst)
    window_done |-> (timer_now == '0));

  // R3: a nonzero timer is always one above its previous value
  p_timer_step_r3: assert property (@(posedge clk) disable iff (rst)
    (timer_now != '0) |-> (timer_now == TMR_W'($past(timer_now) + 1'b1)));

  // R4: running count restarts at the window end
  p_restart_cnt_r4: assert property (@(posedge clk) disable iff (rst)
    window_done |-> (pulse_count_now <= CNT_W'(1)));

  // R5: low-speed event only with a window end and a short count
  p_slow_r5: assert property (@(posedge clk) disable iff (rst)
    slow_event |-> (window_done && (captured_count < $past(vel_cmp_val))));

  // R6: restart zeroes timer and running count
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    vel_clear |=> ((timer_now == '0) && (pulse_count_now == '0) && !window_done));

  // R7: each pulse event follows an accepted strobe
  p_pevt_r7: assert property (@(posedge clk) disable iff (rst)
    pulse_event |-> ($past(enc_pulse) && !$past(vel_clear)));

  // R8: a full counter never drops to a middle value
  p_sat_r8: assert property (@(posedge clk) disable iff (rst)
    (pulse_count_now == CMAX) |=> ((pulse_count_now == CMAX) || (pulse_count_now <= CNT_W'(1))));
endmodule

bind vel_capture_timer vel_capture_timer_chk #(.TMR_W(TMR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/vel_capture_timer_test.sv
module vel_capture_timer_test;
  localparam int TW = 10;
  localparam int CW = 8;
  localparam logic [CW-1:0] CMAX = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enc_pulse = 1'b0, enc_dir = 1'b0, vel_clear = 1'b0;
  logic [TW-1:0] reload_val = TW'(9);
  logic [CW-1:0] vel_cmp_val = CW'(4);
  logic [TW-1:0] timer_now;
  logic [CW-1:0] pulse_count_now, captured_count;
  logic captured_dir, window_done, slow_event, pulse_event;

  always #2 clk = ~clk;   // 250 MHz

  vel_capture_timer #(.TMR_W(TW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .enc_pulse(enc_pulse), .enc_dir(enc_dir),
    .vel_clear(vel_clear), .reload_val(reload_val), .vel_cmp_val(vel_cmp_val),
    .timer_now(timer_now), .pulse_count_now(pulse_count_now),
    .captured_count(captured_count), .captured_dir(captured_dir),
    .window_done(window_done), .slow_event(slow_event), .pulse_event(pulse_event));

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("[TB] FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model + scoreboard queue ----------------
  typedef struct {
    int  cnt;
    bit  slow;
    bit  dir;
    int  rel;
  } cap_item_t;
  cap_item_t sb_q[$];

  int m_tmr = 0, m_rel = 9, m_cnt = 0, m_cap = 0;
  bit m_dir = 0, m_cdir = 0, m_pev = 0, started = 0, clr_since = 1;
  longint cyc = 0, last_done = 0;

  always @(posedge clk) begin
    cap_item_t it;
    started = 1;
    cyc++;
    if (rst) begin
      m_tmr = 0; m_rel = int'(reload_val); m_cnt = 0; m_cap = 0;
      m_dir = 0; m_cdir = 0; m_pev = 0; clr_since = 1;
      sb_q.delete();
    end else begin
      m_pev = enc_pulse && !vel_clear;
      if (vel_clear) begin
        m_tmr = 0; m_rel = int'(reload_val); m_cnt = 0; clr_since = 1;
      end else if (m_tmr == m_rel) begin
        it.cnt = m_cnt; it.slow = (m_cnt < int'(vel_cmp_val));
        it.dir = m_dir; it.rel = m_rel;
        sb_q.push_back(it);
        m_cap = m_cnt; m_cdir = m_dir;
        m_tmr = 0; m_rel = int'(reload_val);
        m_cnt = enc_pulse ? 1 : 0;
      end else begin
        m_tmr++;
        if (enc_pulse && m_cnt != int'(CMAX)) m_cnt++;
      end
      if (m_pev) m_dir = enc_dir;
    end
  end

  // monitor: compare live outputs, pop expected captures
  always @(negedge clk) begin
    cap_item_t it;
    if (started) begin
      chk(rst ? "R1 timer" : "R3 timer", timer_now, m_tmr);
      chk(rst ? "R1 count" : "R4 running count", pulse_count_now, m_cnt);
      chk("R4 captured count", captured_count, m_cap);
      chk("R10 captured dir", captured_dir, m_cdir);
      chk("R7 pulse event", pulse_event, m_pev);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        chk("R2 window done", window_done, 1);
        chk("R4 capture item", captured_count, it.cnt);
        chk("R5 slow event", slow_event, it.slow);
        chk("R10 capture dir item", captured_dir, it.dir);
        if (!clr_since) chk("R2 R9 window length", cyc - last_done, it.rel + 1);
        last_done = cyc; clr_since = 0;
      end else begin
        chk(rst ? "R1 done" : "R2 no stray done", window_done, 0);
        chk(rst ? "R1 slow" : "R5 no stray slow", slow_event, 0);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic drive(input int n, input bit every, input bit toggle_dir);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      enc_pulse = every ? 1'b1 : (i % 2 == 0);
      if (toggle_dir && enc_pulse) enc_dir = ~enc_dir;
    end
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!window_done);
  endtask

  initial begin
    longint t0;
    repeat (4) @(negedge clk);
    chk("R1 reset timer", timer_now, 0);
    chk("R1 reset captured", captured_count, 0);
    chk("R1 reset done", window_done, 0);
    @(negedge clk); rst = 1'b0;

    // idle windows: zero count, below threshold
    wait_done(); wait_done();
    chk("R5 idle slow", slow_event, 1);

    // strobe on every cycle, boundary strobes move to new window
    vel_cmp_val = CW'(10);
    drive(25, 1, 0);
    wait_done(); wait_done();
    chk("R4 full window count", captured_count, 10);
    chk("R5 equal not slow", slow_event, 0);
    vel_cmp_val = CW'(11);
    wait_done();
    chk("R5 one short is slow", slow_event, 1);

    // alternate strobes with toggling direction
    drive(40, 0, 1);
    enc_dir = 1'b1; drive(6, 0, 0);
    @(negedge clk); enc_pulse = 1'b0;
    wait_done(); wait_done();
    chk("R10 dir held without strobes", captured_dir, 1);

    // reload change right after a window end
    wait_done();
    reload_val = TW'(3);
    t0 = cyc;
    wait_done();
    chk("R9 old length kept", cyc - t0, 10);
    t0 = cyc;
    wait_done();
    chk("R9 new length used", cyc - t0, 4);

    // restart together with a strobe
    reload_val = TW'(20);
    drive(3, 1, 0);
    @(negedge clk); vel_clear = 1'b1; enc_pulse = 1'b1;
    @(negedge clk); vel_clear = 1'b0; enc_pulse = 1'b0;
    chk("R6 timer cleared", timer_now, 0);
    chk("R6 count cleared", pulse_count_now, 0);
    chk("R6 strobe dropped", pulse_event, 0);
    wait_done();

    // saturation in a long window
    reload_val = TW'(400); vel_cmp_val = CMAX;
    wait_done();
    enc_pulse = 1'b1;
    wait_done();
    chk("R8 saturated capture", captured_count, int'(CMAX));
    chk("R8 saturated not slow", slow_event, 0);
    enc_pulse = 1'b0;

    // reset in mid window
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset timer", timer_now, 0);
    chk("R1 mid reset count", pulse_count_now, 0);
    chk("R1 mid reset captured", captured_count, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("[TB] FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule